// File: doc/BRIEF.md
# Shared Bus Arbiter with Parking and Split Masking

This block decides which of several bus masters owns a shared AHB-style system bus. Every master drives a request line. The arbiter answers with a registered one-hot grant vector and the binary index of the current owner. A build-time parameter selects the policy. Round-robin shares the bus fairly. Fixed priority always favours the requesting master with the largest index.

Ownership moves only on a clock edge where the ready input reports the end of a transfer. It never moves while the current owner holds its lock line high. When no master is eligible, the bus is parked on a default master chosen by a parameter, which must be smaller than the master count. The default for that parameter is master 0.

An optional split feature lets a slave push a master out of arbitration with a per-master split bit. The master stays out until the matching release bit is seen. When the feature is turned off at build time, the masking logic is not generated and the split inputs have no effect.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is asserted, `owner_o` equals `DEFAULT_MST`, and `grant_o` has only bit `DEFAULT_MST` set.
- R2: After reset, `grant_o` always has exactly one bit set, and that bit is the one at index `owner_o`.
- R3: On a rising edge where `ready_i` is low, `owner_o` and `grant_o` keep their values.
- R4: On a rising edge where `ready_i` is high and `lock_i[owner_o]` is high, the owner keeps the bus.
- R5: A master is eligible when its request bit is high and it is not split-masked. On a rising edge where `ready_i` is high, the owner is unlocked and no master is eligible, the owner becomes `DEFAULT_MST`.
- R6: With `POLICY = POL_FIXED`, on a rising edge where `ready_i` is high and the owner is unlocked, the eligible master with the highest index becomes the owner.
- R7: With `POLICY = POL_RR`, on a rising edge where `ready_i` is high and the owner is unlocked, the new owner is the first eligible master found by scanning indices owner+1, owner+2 and onward, wrapping from NUM_MST-1 to 0. The current owner is scanned last.
- R8: With `SPLIT_EN = 1`, a high `split_i[i]` at a rising edge masks master i starting at that same edge. The mask is cleared at an edge where `split_rel_i[i]` is high and `split_i[i]` is low. If both are high at the same edge, the master stays masked.
- R9: With `SPLIT_EN = 0`, `split_i` and `split_rel_i` have no effect on ownership.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_MST | Request, one bit per master |
| lock_i | input | NUM_MST | Lock, one bit per master; holds the bus while set on the owner |
| ready_i | input | 1 | Transfer boundary; ownership may change only when high |
| split_i | input | NUM_MST | Split response, one bit per master; masks that master |
| split_rel_i | input | NUM_MST | Split release, one bit per master; unmasks that master |
| grant_o | output | NUM_MST | One-hot grant |
| owner_o | output | OWN_W | Index of the current owner |

## Verification
The hardest situations to reach from the ports are a masked master that keeps requesting while the round-robin scan wraps past it, and a split bit and a release bit for the same master arriving at the same edge. Random stimulus alone seldom produces either. The bench therefore runs directed sequences that hold all requests high, split one master, rotate the bus and then release it, including a simultaneous split and release. A long random phase with sparse split, lock and ready-low cycles follows. Two instances with different policies, split settings and default masters are compared, every cycle, against a bench model of the rules.

// File: rtl/arb_pkg.sv
package arb_pkg;
    typedef enum logic {
        POL_FIXED = 1'b0,
        POL_RR    = 1'b1
    } policy_e;
endpackage

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
    parameter int unsigned NUM_MST  = 4,
    parameter bit          SPLIT_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] split_i,
    input  logic [NUM_MST-1:0] split_rel_i,
    output logic [NUM_MST-1:0] mask_o
);
    generate
        if (SPLIT_EN) begin : g_mask
            logic [NUM_MST-1:0] mask_d, mask_q;

            always_comb begin
                // a new split wins over a release arriving at the same edge
                mask_d = (mask_q & ~split_rel_i) | split_i;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mask_q <= '0;
                else        mask_q <= mask_d;
            end

            // the mask seen by arbitration already includes this edge's update
            assign mask_o = mask_d;

            AST_SPLIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
                (split_i != '0) |=> ((mask_q & $past(split_i)) == $past(split_i))); // R8
            AST_SPLIT_REL: assert property (@(posedge clk) disable iff (!rst_n)
                ((split_rel_i & ~split_i) != '0) |=> ((mask_q & $past(split_rel_i & ~split_i)) == '0)); // R8
        end else begin : g_nomask
            logic unused_in;
            assign unused_in = ^{clk, rst_n, split_i, split_rel_i};
            assign mask_o    = '0;
        end
    endgenerate
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int unsigned      NUM_MST = 4,
    parameter int unsigned      OWN_W   = 2,
    parameter arb_pkg::policy_e POLICY  = arb_pkg::POL_RR
) (
    input  logic [NUM_MST-1:0] elig_i,
    input  logic [OWN_W-1:0]   last_i,
    output logic [OWN_W-1:0]   pick_o,
    output logic               any_o
);
    assign any_o = |elig_i;

    generate
        if (POLICY == arb_pkg::POL_FIXED) begin : g_fixed
            logic unused_last;
            assign unused_last = ^last_i;
            always_comb begin
                pick_o = '0;
                for (int i = 0; i < int'(NUM_MST); i++) begin
                    if (elig_i[i]) pick_o = OWN_W'(i);   // later index overrides
                end
            end
        end else begin : g_rr
            always_comb begin
                logic found;
                int   idx;
                found  = 1'b0;
                pick_o = last_i;
                for (int k = 1; k <= int'(NUM_MST); k++) begin
                    idx = (int'(last_i) + k) % int'(NUM_MST);
                    if (!found && elig_i[idx]) begin
                        found  = 1'b1;
                        pick_o = OWN_W'(idx);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int unsigned      NUM_MST     = 4,
    parameter arb_pkg::policy_e POLICY      = arb_pkg::POL_RR,
    parameter int unsigned      DEFAULT_MST = 0,
    parameter bit               SPLIT_EN    = 1'b1,
    localparam int unsigned     OWN_W       = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_MST-1:0] req_i,
    input  logic [NUM_MST-1:0] lock_i,
    input  logic               ready_i,
    input  logic [NUM_MST-1:0] split_i,
    input  logic [NUM_MST-1:0] split_rel_i,
    output logic [NUM_MST-1:0] grant_o,
    output logic [OWN_W-1:0]   owner_o
);
    localparam logic [OWN_W-1:0] DFLT = OWN_W'(DEFAULT_MST);

    typedef struct packed {
        logic [OWN_W-1:0]   owner;
        logic [NUM_MST-1:0] grant;
    } arb_state_t;

    arb_state_t         st_d, st_q;
    logic [NUM_MST-1:0] mask;
    logic [NUM_MST-1:0] elig;
    logic [OWN_W-1:0]   pick;
    logic               any_elig;

    arb_split_mask #(.NUM_MST(NUM_MST), .SPLIT_EN(SPLIT_EN)) i_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .split_i     (split_i),
        .split_rel_i (split_rel_i),
        .mask_o      (mask)
    );

    assign elig = req_i & ~mask;

    arb_pick #(.NUM_MST(NUM_MST), .OWN_W(OWN_W), .POLICY(POLICY)) i_pick (
        .elig_i (elig),
        .last_i (st_q.owner),
        .pick_o (pick),
        .any_o  (any_elig)
    );

    always_comb begin
        st_d = st_q;
        if (ready_i && !lock_i[st_q.owner]) begin
            st_d.owner            = any_elig ? pick : DFLT;
            st_d.grant            = '0;
            st_d.grant[st_d.owner] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.owner       <= DFLT;
            st_q.grant       <= '0;
            st_q.grant[DFLT] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_o = st_q.owner;
    assign grant_o = st_q.grant;

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1); // R2
    AST_GRANT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o[owner_o]); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(owner_o)); // R3
    AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && lock_i[owner_o]) |=> $stable(owner_o)); // R4
    AST_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !lock_i[owner_o] && ((req_i & ~mask) == '0)) |=> (owner_o == DFLT)); // R5
    AST_WINNER_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !lock_i[owner_o] && ((req_i & ~mask) != '0)) |=> $past(elig[pick])); // R6 R7 R8
endmodule

// File: tb/test_bus_arbiter.sv
module test_bus_arbiter;
    localparam int unsigned N  = 4;
    localparam int unsigned W  = 2;
    localparam int unsigned DA = 0;
    localparam int unsigned DB = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0, lock = '0, split = '0, rel = '0;
    logic         ready = 1'b0;
    logic [N-1:0] grant_a, grant_b;
    logic [W-1:0] owner_a, owner_b;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bus_arbiter #(.NUM_MST(N), .POLICY(arb_pkg::POL_RR), .DEFAULT_MST(DA), .SPLIT_EN(1'b1)) i_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .ready_i(ready),
        .split_i(split), .split_rel_i(rel), .grant_o(grant_a), .owner_o(owner_a));

    bus_arbiter #(.NUM_MST(N), .POLICY(arb_pkg::POL_FIXED), .DEFAULT_MST(DB), .SPLIT_EN(1'b0)) i_bus_arbiter_fp (
        .clk(clk), .rst_n(rst_n), .req_i(req), .lock_i(lock), .ready_i(ready),
        .split_i(split), .split_rel_i(rel), .grant_o(grant_b), .owner_o(owner_b));

    // reference rules, independent of the RTL structure
    function automatic int rr_next(int last, logic [N-1:0] el, int dflt);
        for (int k = 1; k <= int'(N); k++) begin
            if (el[(last + k) % int'(N)]) return (last + k) % int'(N);
        end
        return dflt;
    endfunction

    function automatic int fixed_next(logic [N-1:0] el, int dflt);
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (el[i]) return i;
        end
        return dflt;
    endfunction

    int           m_own_a = DA, m_own_b = DB;
    logic [N-1:0] m_mask = '0;
    string        tag_a = "R1", tag_b = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_own_a <= DA; m_own_b <= DB; m_mask <= '0;
            tag_a <= "R1"; tag_b <= "R1";
        end else begin
            logic [N-1:0] nm;
            nm = (m_mask & ~rel) | split;
            m_mask <= nm;
            if (!ready) tag_a <= "R3";
            else if (lock[m_own_a]) tag_a <= "R4";
            else begin
                m_own_a <= rr_next(m_own_a, req & ~nm, DA);
                tag_a <= ((req & ~nm) == '0) ? "R5" : (nm != '0) ? "R8" : "R7";
            end
            if (!ready) tag_b <= "R3";
            else if (lock[m_own_b]) tag_b <= "R4";
            else begin
                m_own_b <= fixed_next(req, DB);
                tag_b <= (split | rel) != '0 ? "R9" : (req == '0) ? "R5" : "R6";
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        check(tag_a, int'(owner_a), m_own_a);
        check(tag_b, int'(owner_b), m_own_b);
        check("R2", int'(grant_a), 1 << owner_a);
        check("R2", int'(grant_b), 1 << owner_b);
    endtask

    task automatic step(logic [N-1:0] r, logic [N-1:0] lk, logic rd, logic [N-1:0] sp, logic [N-1:0] rl);
        @(negedge clk);
        check_outputs();
        req = r; lock = lk; ready = rd; split = sp; rel = rl;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        // R1: reset state, while reset is held
        check("R1", int'(owner_a), DA);
        check("R1", int'(owner_b), DB);
        check("R1", int'(grant_a), 1 << DA);
        check("R1", int'(grant_b), 1 << DB);
        rst_n = 1'b1;

        // R7 wrap and R6 priority with all requesting
        repeat (6) step(4'b1111, '0, 1'b1, '0, '0);
        // R3 hold with ready low
        repeat (3) step(4'b1111, '0, 1'b0, '0, '0);
        // R8 split master 1, rotate past it, then a simultaneous split and release, then release
        step(4'b1111, '0, 1'b1, 4'b0010, '0);
        repeat (5) step(4'b1111, '0, 1'b1, '0, '0);
        step(4'b1111, '0, 1'b1, 4'b0010, 4'b0010);
        repeat (4) step(4'b0010, '0, 1'b1, '0, '0);
        step(4'b1111, '0, 1'b1, '0, 4'b0010);
        repeat (4) step(4'b1111, '0, 1'b1, '0, '0);
        // R4 lock held by whoever owns the bus, then R5 parking
        repeat (3) step(4'b1111, 4'b1111, 1'b1, '0, '0);
        repeat (2) step(4'b0000, '0, 1'b1, '0, '0);
        // R9 split activity on the fixed instance with a single requester
        repeat (3) step(4'b0001, '0, 1'b1, 4'b0001, '0);
        step('0, '0, 1'b1, '0, 4'b1111);

        // constrained random phase
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] r, lk, sp, rl;
            r  = ($urandom % 6 == 0) ? '0 : N'($urandom);
            lk = ($urandom % 8 == 0) ? N'($urandom) : '0;
            sp = ($urandom % 12 == 0) ? N'(1 << ($urandom % N)) : '0;
            rl = ($urandom % 5 == 0) ? N'($urandom) : '0;
            step(r, lk, ($urandom % 4) != 0, sp, rl);
        end
        @(negedge clk);
        check_outputs();
        finish_run();
    end
endmodule